// File: doc/BRIEF.md
# Split-Phase Bus Target Responder

This block is the target side of a 32-bit expansion card on a bus whose cycles are split into an address phase and a transfer phase. The master holds an active-low address-phase strobe low for one bus clock and then lowers an active-low transfer-phase strobe, which stays low until the cycle ends. On the trailing (rising) edge of the address-phase strobe the block captures the word address, the byte enables and the direction and space lines, and it decides whether the card is selected by comparing the address against a base value under a mask.

A selected cycle is acknowledged on the width line and the I/O-width line. The ready line is held low for wait states until a configurable number of falling bus-clock strobes have passed and the local side reports it is ready. Each beat ends on the next rising bus-clock strobe that sees the ready line released. Reads drive local data onto the bus, and writes merge the bus data into a local register lane by lane. The block offers burst transfers, and it keeps a burst going for as long as the master confirms it at each beat end. Bus-clock edges reach the block as one-clock strobes on a faster system clock.

Top module: `xbus_target`

## Requirements
- R1: During and after reset, every response line (`ack32_n`, `ack16_n`, `ioack_n`, `wait_n`, `sburst_n`) is high, `resp_oe`, `rdata_oe` and `wr_valid` are 0, and `wr_data` is 0.
- R2: Address, byte enables and direction are captured at the first clock on which `adr_ph_n` is seen high after being low. The cycle is selected when `((bus_addr ^ cfg_base) & cfg_mask) == 0` and `bus_mem` equals `MEM_TARGET` (default 1, memory space). From the next clock until the cycle ends, `ack32_n` and `ioack_n` are low, and `loc_addr` holds the captured address.
- R3: In the default 32-bit variant (`WIDE32` = 1), `ack16_n` never goes low. At most one width acknowledge is low at any time.
- R4: After selection, `wait_n` stays low until at least `cfg_wait` falling bus-clock strobes have been seen while `loc_ready` is high. It then goes high.
- R5: While `loc_ready` is low, a low `wait_n` stays low.
- R6: A beat completes on a clock where `bclk_rise` is 1, `xfer_ph_n` is 0 and `wait_n` is high. A write beat raises `wr_valid` for exactly the following clock.
- R7: `rdata_oe` is 1 only while selected, with `xfer_ph_n` low and a read cycle. While it is 1, `rdata_out` equals `loc_rdata`; otherwise `rdata_out` is 0.
- R8: On a write beat, byte lane i (bits 8i+7..8i) of `wr_data` takes the bus data when `bus_be_n[i]` is 0 and is kept when it is 1.
- R9: `sburst_n` is low throughout a selected cycle (burst offered, `BURST_EN` = 1).
- R10: If `mburst_n` is low at a beat end, the cycle continues with a new beat and a fresh wait count. If it is high, every response line is released on the next clock.
- R11: An unselected cycle (address outside the window, or the wrong space) drives no response line and leaves `wr_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_rise | input | 1 | One-clock strobe at each rising bus-clock edge |
| bclk_fall | input | 1 | One-clock strobe at each falling bus-clock edge |
| adr_ph_n | input | 1 | Address-phase strobe, active low |
| xfer_ph_n | input | 1 | Transfer-phase strobe, active low |
| bus_addr | input | ADDR_W-2 | Word address lines |
| bus_be_n | input | DATA_W/8 | Byte enables, active low, bit i = lane i |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_mem | input | 1 | 1 = memory space, 0 = I/O space |
| mburst_n | input | 1 | Master burst confirm, active low |
| wdata_in | input | DATA_W | Write data from the bus |
| cfg_base | input | ADDR_W-2 | Window base word address |
| cfg_mask | input | ADDR_W-2 | Bits of the address that take part in the compare |
| cfg_wait | input | WAIT_W | Minimum falling strobes before ready |
| loc_ready | input | 1 | Local side ready |
| loc_rdata | input | DATA_W | Local read data |
| ack32_n | output | 1 | 32-bit width acknowledge, active low |
| ack16_n | output | 1 | 16-bit width acknowledge, active low |
| ioack_n | output | 1 | 16-bit I/O indicator, active low |
| wait_n | output | 1 | Ready line, low inserts wait states |
| sburst_n | output | 1 | Burst offer, active low |
| resp_oe | output | 1 | Drive enable of the response lines |
| rdata_out | output | DATA_W | Read data onto the bus |
| rdata_oe | output | 1 | Drive enable of the read data |
| loc_addr | output | ADDR_W-2 | Captured word address |
| loc_be | output | DATA_W/8 | Captured byte enables |
| loc_wr | output | 1 | Captured direction |
| wr_data | output | DATA_W | Local write register |
| wr_valid | output | 1 | One-clock pulse after a write beat |

## Verification
Several relations are checked by assertions on every clock. A response begins only right after a trailing address-phase edge. Read data is never enabled outside a read transfer phase. At most one width acknowledge is low. The ready line rises only after the local side reported ready, and it stays low while that input is low. A write pulse follows a completed beat, and untouched lanes keep their value. A beat end without burst confirmation releases the lines. The bench scenarios cover what needs a model of the bus: the window decode against base and mask, the number of falling strobes before release, the merged write data across partial byte enables and multi-beat bursts, the returned read data, and reset in the middle of a cycle.

// File: rtl/xbt_pkg.sv
// Shared types of the split-phase bus target.
// Assumes: nothing beyond the parameters of the users.
package xbt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACT  = 1'b1
    } xbt_state_e;
endpackage

// File: rtl/xbt_decode.sv
// Window decode: a cycle is selected when the masked address matches the
// masked base and the space line equals the space the card lives in.
// Assumes: inputs are stable in the clock the result is used.
module xbt_decode #(
    parameter int ADDR_W     = 32,
    parameter bit MEM_TARGET = 1'b1
) (
    input  logic [ADDR_W-3:0] addr,
    input  logic [ADDR_W-3:0] base,
    input  logic [ADDR_W-3:0] mask,
    input  logic              mem,
    output logic              hit
);
    // Purpose: compare under mask and check the space.
    always_comb begin
        hit = (((addr ^ base) & mask) == '0) && (mem == MEM_TARGET);
    end
endmodule

// File: rtl/xbt_waitgen.sv
// Wait-state generator: on load the counter takes the configured count and
// ready drops; each falling bus strobe lowers the count; ready becomes set
// (and sticks) once the count is zero and the local side is ready.
// Assumes: load is a one-clock pulse at the start of each beat.
module xbt_waitgen #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fall,
    input  logic              loc_ready,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              rdy
);
    logic [WAIT_W-1:0] cnt;

    // Purpose: count falling strobes and raise ready when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (load) begin
            cnt <= cfg_wait;
            rdy <= 1'b0;
        end else begin
            if (fall && (cnt != '0)) begin
                cnt <= cnt - 1'b1;
            end
            if ((cnt == '0) && loc_ready) begin
                rdy <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xbt_lanes.sv
// Local write register: each byte lane takes the bus data on a write beat
// when its active-low enable is low, and holds its value otherwise.
// Assumes: DATA_W is a multiple of 8.
module xbt_lanes #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [DATA_W/8-1:0] be_n,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   q
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Purpose: update one byte lane under its enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[8*i +: 8] <= '0;
            end else if (we && !be_n[i]) begin
                q[8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/xbus_target.sv
// Target responder for a bus with an address phase and a transfer phase.
// Captures the cycle on the trailing edge of the address-phase strobe,
// decodes a window, acknowledges width, inserts wait states, returns read
// data or merges write data, and follows the master's burst confirmation.
// Assumes: bus-clock edges arrive as one-clock strobes on clk; bus inputs
// are synchronous to clk.
module xbus_target
    import xbt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAIT_W     = 4,
    parameter bit WIDE32     = 1'b1,
    parameter bit BURST_EN   = 1'b1,
    parameter bit MEM_TARGET = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_rise,
    input  logic                bclk_fall,
    input  logic                adr_ph_n,
    input  logic                xfer_ph_n,
    input  logic [ADDR_W-3:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be_n,
    input  logic                bus_wr,
    input  logic                bus_mem,
    input  logic                mburst_n,
    input  logic [DATA_W-1:0]   wdata_in,
    input  logic [ADDR_W-3:0]   cfg_base,
    input  logic [ADDR_W-3:0]   cfg_mask,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                loc_ready,
    input  logic [DATA_W-1:0]   loc_rdata,
    output logic                ack32_n,
    output logic                ack16_n,
    output logic                ioack_n,
    output logic                wait_n,
    output logic                sburst_n,
    output logic                resp_oe,
    output logic [DATA_W-1:0]   rdata_out,
    output logic                rdata_oe,
    output logic [ADDR_W-3:0]   loc_addr,
    output logic [DATA_W/8-1:0] loc_be,
    output logic                loc_wr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                wr_valid
);
    localparam int LANES = DATA_W / 8;

    xbt_state_e       state;
    logic             adr_q;
    logic             trail;
    logic             hit;
    logic             sel;
    logic             rdy;
    logic             act;
    logic             beat_done;
    logic             cont;
    logic             load;
    logic             wr_we;
    logic [LANES-1:0] beat_be_n;

    // Purpose: remember the previous address-phase strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q <= 1'b1;
        end else begin
            adr_q <= adr_ph_n;
        end
    end

    xbt_decode #(
        .ADDR_W     (ADDR_W),
        .MEM_TARGET (MEM_TARGET)
    ) u_dec (
        .addr (bus_addr),
        .base (cfg_base),
        .mask (cfg_mask),
        .mem  (bus_mem),
        .hit  (hit)
    );

    // Purpose: derive the cycle events from strobes and state.
    always_comb begin
        act       = (state == ST_ACT);
        trail     = !adr_q && adr_ph_n;
        sel       = trail && hit && !act;
        beat_done = act && !xfer_ph_n && bclk_rise && rdy;
        cont      = beat_done && BURST_EN && !mburst_n;
        load      = sel || cont;
        wr_we     = beat_done && loc_wr;
        beat_be_n = bus_be_n;
    end

    // Purpose: cycle state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (sel) state <= ST_ACT;
                ST_ACT: begin
                    if (xfer_ph_n) begin
                        state <= ST_IDLE;
                    end else if (beat_done && !cont) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: capture address, enables and direction at selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_addr <= '0;
            loc_be   <= '1;
            loc_wr   <= 1'b0;
        end else if (sel) begin
            loc_addr <= bus_addr;
            loc_be   <= bus_be_n;
            loc_wr   <= bus_wr;
        end
    end

    xbt_waitgen #(
        .WAIT_W (WAIT_W)
    ) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .fall      (bclk_fall),
        .loc_ready (loc_ready),
        .cfg_wait  (cfg_wait),
        .rdy       (rdy)
    );

    xbt_lanes #(
        .DATA_W (DATA_W)
    ) u_lanes (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_we),
        .be_n  (beat_be_n),
        .wdata (wdata_in),
        .q     (wr_data)
    );

    // Purpose: one-clock pulse after a completed write beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
        end else begin
            wr_valid <= wr_we;
        end
    end

    // Purpose: width acknowledge for the selected variant.
    if (WIDE32) begin : g_wide
        always_comb begin
            ack32_n = !act;
            ack16_n = 1'b1;
        end
    end else begin : g_narrow
        always_comb begin
            ack32_n = 1'b1;
            ack16_n = !act;
        end
    end

    // Purpose: remaining response lines and the read data path.
    always_comb begin
        ioack_n   = !act;
        wait_n    = !act || rdy;
        sburst_n  = !(act && BURST_EN);
        resp_oe   = act;
        rdata_oe  = act && !xfer_ph_n && !loc_wr;
        rdata_out = rdata_oe ? loc_rdata : '0;
    end
endmodule

// File: rtl/xbus_target_chk.sv
// Checker for xbus_target, attached by bind; observes ports only.
// Assumes: the same parameters as the bound instance.
module xbus_target_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WAIT_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk_rise,
    input logic                bclk_fall,
    input logic                adr_ph_n,
    input logic                xfer_ph_n,
    input logic [ADDR_W-3:0]   bus_addr,
    input logic [DATA_W/8-1:0] bus_be_n,
    input logic                bus_wr,
    input logic                bus_mem,
    input logic                mburst_n,
    input logic [DATA_W-1:0]   wdata_in,
    input logic [ADDR_W-3:0]   cfg_base,
    input logic [ADDR_W-3:0]   cfg_mask,
    input logic [WAIT_W-1:0]   cfg_wait,
    input logic                loc_ready,
    input logic [DATA_W-1:0]   loc_rdata,
    input logic                ack32_n,
    input logic                ack16_n,
    input logic                ioack_n,
    input logic                wait_n,
    input logic                sburst_n,
    input logic                resp_oe,
    input logic [DATA_W-1:0]   rdata_out,
    input logic                rdata_oe,
    input logic [ADDR_W-3:0]   loc_addr,
    input logic [DATA_W/8-1:0] loc_be,
    input logic                loc_wr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                wr_valid
);
    // R2: a response starts only right after a trailing address-phase edge
    p_start_after_trail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_oe) |-> $past(adr_ph_n) && $past(!adr_ph_n, 2));

    // R3: at most one width acknowledge low
    p_one_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ack32_n, !ack16_n}));

    // R4: the ready line rises in a cycle only after local ready was seen
    p_ready_after_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wait_n) && resp_oe) |-> $past(loc_ready));

    // R5: low ready line holds while the local side is not ready
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_oe && !wait_n && !loc_ready) |=> (!wait_n || !resp_oe));

    // R6: a write pulse follows a completed beat
    p_wr_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(bclk_rise && wait_n && !xfer_ph_n && resp_oe && loc_wr));

    // R7: read data only in a selected read transfer phase
    p_rd_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!xfer_ph_n && resp_oe && !loc_wr && rdata_out == loc_rdata));

    // R10: a beat end without burst confirmation releases the lines
    p_burst_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_oe && bclk_rise && wait_n && !xfer_ph_n && mburst_n) |=> !resp_oe && ack32_n && wait_n);

    // R8: lanes whose enable was high keep their value on a write
    for (genvar i = 0; i < DATA_W/8; i++) begin : g_keep
        p_lane_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_valid && $past(bus_be_n[i])) |-> wr_data[8*i +: 8] == $past(wr_data[8*i +: 8]));
    end
endmodule

bind xbus_target xbus_target_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WAIT_W (WAIT_W)
) u_chk (.*);

// File: tb/sim_xbus_target.sv
module sim_xbus_target;
    localparam logic [29:0] BASE = 30'h0010_0000;
    localparam logic [29:0] MASK = 30'h3FF0_0000;

    typedef struct packed {
        logic [29:0] addr;
        logic        wr;
        logic        mem;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic [3:0]  waits;
        logic [2:0]  beats;
        logic [2:0]  hold;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{30'h0010_0004, 1'b1, 1'b1, 4'b0000, 32'hA1B2C3D4, 4'd0, 3'd1, 3'd0},
        '{30'h0010_0008, 1'b0, 1'b1, 4'b0000, 32'h0,        4'd2, 3'd1, 3'd0},
        '{30'h001F_FFFF, 1'b1, 1'b1, 4'b1100, 32'h11223344, 4'd1, 3'd1, 3'd0},
        '{30'h0020_0000, 1'b1, 1'b1, 4'b0000, 32'hFFFFFFFF, 4'd0, 3'd1, 3'd0},
        '{30'h0010_0010, 1'b1, 1'b0, 4'b0000, 32'hEEEEEEEE, 4'd0, 3'd1, 3'd0},
        '{30'h0010_0020, 1'b1, 1'b1, 4'b0000, 32'h50000000, 4'd0, 3'd3, 3'd0},
        '{30'h0010_0030, 1'b0, 1'b1, 4'b0000, 32'h0,        4'd3, 3'd2, 3'd0},
        '{30'h0010_0040, 1'b1, 1'b1, 4'b0111, 32'h99000000, 4'd0, 3'd1, 3'd0},
        '{30'h0010_0050, 1'b0, 1'b1, 4'b0000, 32'h0,        4'd0, 3'd1, 3'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_rise = 1'b0, bclk_fall = 1'b0;
    logic        adr_ph_n = 1'b1, xfer_ph_n = 1'b1;
    logic [29:0] bus_addr = '0;
    logic [3:0]  bus_be_n = '1;
    logic        bus_wr = 1'b0, bus_mem = 1'b1, mburst_n = 1'b1;
    logic [31:0] wdata_in = '0;
    logic [3:0]  cfg_wait = '0;
    logic        loc_ready = 1'b1;
    logic [31:0] loc_rdata = 32'hDEAD0000;
    logic        ack32_n, ack16_n, ioack_n, wait_n, sburst_n, resp_oe, rdata_oe;
    logic [31:0] rdata_out, wr_data;
    logic [29:0] loc_addr;
    logic [3:0]  loc_be;
    logic        loc_wr, wr_valid;

    int          errors = 0;
    int          checks = 0;
    logic [31:0] exp_wr = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    xbus_target u0 (
        .clk(clk), .rst_n(rst_n), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
        .adr_ph_n(adr_ph_n), .xfer_ph_n(xfer_ph_n), .bus_addr(bus_addr),
        .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_mem(bus_mem), .mburst_n(mburst_n),
        .wdata_in(wdata_in), .cfg_base(BASE), .cfg_mask(MASK), .cfg_wait(cfg_wait),
        .loc_ready(loc_ready), .loc_rdata(loc_rdata), .ack32_n(ack32_n),
        .ack16_n(ack16_n), .ioack_n(ioack_n), .wait_n(wait_n), .sburst_n(sburst_n),
        .resp_oe(resp_oe), .rdata_out(rdata_out), .rdata_oe(rdata_oe),
        .loc_addr(loc_addr), .loc_be(loc_be), .loc_wr(loc_wr),
        .wr_data(wr_data), .wr_valid(wr_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be_n);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++) if (!be_n[i]) r[8*i +: 8] = d[8*i +: 8];
        return r;
    endfunction

    task automatic released(input string req);
        chk(ack32_n && ack16_n && ioack_n && wait_n && sburst_n && !resp_oe && !rdata_oe,
            req, {25'b0, ack32_n, ack16_n, ioack_n, wait_n, sburst_n, resp_oe, rdata_oe}, 32'h7C);
    endtask

    // Address phase for one bus clock, then trailing edge with transfer phase.
    task automatic start_cycle(input vec_t v);
        @(negedge clk);
        bus_addr = v.addr; bus_wr = v.wr; bus_mem = v.mem; bus_be_n = v.be_n;
        wdata_in = v.wdata; cfg_wait = v.waits; adr_ph_n = 1'b0; mburst_n = 1'b1;
        loc_ready = (v.hold == 0); loc_rdata = 32'hDEAD0000;
        for (int c = 0; c < 4; c++) begin
            if (c != 0) @(negedge clk);
            bclk_rise = (c == 0); bclk_fall = (c == 2);
        end
        @(negedge clk);
        adr_ph_n = 1'b1; xfer_ph_n = 1'b0; bclk_rise = 1'b1; bclk_fall = 1'b0;
        mburst_n = (v.beats > 1) ? 1'b0 : 1'b1;
    endtask

    task automatic run_txn(input vec_t v);
        bit hit;
        int falls, beat, periods, cyc;
        bit just_done, seen;
        hit = ((((v.addr ^ BASE) & MASK) == 0) && v.mem);
        start_cycle(v);
        falls = 0; beat = 0; periods = 0; just_done = 0; seen = 0;
        if (!hit) begin
            for (int c = 1; c < 9; c++) begin
                @(negedge clk);
                bclk_rise = (c % 4 == 0); bclk_fall = (c % 4 == 2);
                released("R11 miss drives nothing");
            end
            chk(wr_data == exp_wr, "R11 miss keeps write data", wr_data, exp_wr);
        end else begin
            for (cyc = 1; cyc < 400 && beat < v.beats; cyc++) begin
                @(negedge clk);
                if (just_done) begin
                    just_done = 0;
                    if (v.wr) begin
                        exp_wr = merge(exp_wr, wdata_in, v.be_n);
                        chk(wr_valid == 1'b1, "R6 write pulse", {31'b0, wr_valid}, 1);
                        chk(wr_data == exp_wr, "R8 lane merge", wr_data, exp_wr);
                    end
                    beat++;
                    if (beat < v.beats) begin
                        chk(resp_oe == 1'b1, "R10 burst continues", {31'b0, resp_oe}, 1);
                        wdata_in = v.wdata + beat; loc_rdata = 32'hDEAD0000 + beat;
                    end else begin
                        released("R10 release after last beat");
                    end
                    falls = 0; seen = 0;
                end
                if (cyc == 1) begin
                    chk(!ack32_n && !ioack_n && !sburst_n && resp_oe, "R2/R9 acknowledge",
                        {28'b0, ack32_n, ioack_n, sburst_n, resp_oe}, 32'h1);
                    chk(ack16_n == 1'b1, "R3 narrow ack idle", {31'b0, ack16_n}, 1);
                    chk(loc_addr == v.addr, "R2 address capture", {2'b0, loc_addr}, {2'b0, v.addr});
                end
                if (beat >= v.beats) break;
                bclk_rise = (cyc % 4 == 0); bclk_fall = (cyc % 4 == 2);
                if (cyc % 4 == 2) falls++;
                if (cyc % 4 == 0) begin
                    if (periods < v.hold) begin
                        chk(wait_n == 1'b0, "R5 wait held while local not ready", {31'b0, wait_n}, 0);
                        periods++;
                        if (periods == v.hold) loc_ready = 1'b1;
                    end else if (wait_n) begin
                        if (!seen) begin
                            chk(falls >= v.waits, "R4 wait count honoured", falls, v.waits);
                            seen = 1;
                        end
                        if (!v.wr) begin
                            chk(rdata_oe && rdata_out == loc_rdata, "R7 read data", rdata_out, loc_rdata);
                        end
                        mburst_n = (beat + 1 < v.beats) ? 1'b0 : 1'b1;
                        just_done = 1;
                    end
                end
            end
            chk(beat == v.beats, "R4 ready eventually released", beat, v.beats);
        end
        @(negedge clk);
        xfer_ph_n = 1'b1; bclk_rise = 1'b0; bclk_fall = 1'b0; mburst_n = 1'b1; loc_ready = 1'b1;
        @(negedge clk);
        released("R1 idle after cycle");
        chk(rdata_out == 0, "R7 no read data when idle", rdata_out, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        released("R1 reset state");
        chk(wr_data == 0 && wr_valid == 0, "R1 reset write state", wr_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        released("R1 idle after reset");
        for (int k = 0; k < NV; k++) run_txn(VEC[k]);
        // Reset in the middle of a selected cycle.
        start_cycle(VEC[1]);
        @(negedge clk);
        bclk_rise = 1'b0;
        chk(resp_oe == 1'b1, "R2 selected before reset", {31'b0, resp_oe}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        released("R1 reset mid cycle");
        chk(wr_data == 0, "R1 reset clears write data", wr_data, 0);
        xfer_ph_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        released("R1 idle after mid reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule